// File: doc/BRIEF.md
# Banked Nibble Real-Time Clock Register File

This block is a real-time clock register file that a host sees as sixteen 4-bit registers. The mode register sits at address 0xD. Its two low bits choose which of four banks appears at the thirteen low addresses. Bank 0 holds the BCD time and calendar digits. Bank 1 holds configuration: alarm nibbles, the 12/24-hour select and the leap-year counter. Banks 2 and 3 are general-purpose nibble RAM. The test register and the reset/control register sit above the mode register and are reachable from every bank.

A one-second tick input drives the BCD counter chain. The chain runs seconds, minutes, hours, day of week, day of month, month, year and the leap-year counter. Clearing the timer-enable bit freezes the chain, so software can read or write all the digits as one consistent snapshot. A tick that arrives while the chain is frozen is kept as a single pending carry. That carry is applied once the chain runs again.

Top module: `nrtc_regfile`

## Requirements
- R1: Address 0xD is the mode register: bit 3 timer enable, bit 2 alarm enable, bits 1:0 bank (0 time, 1 configuration, 2 RAM A, 3 RAM B). It reads back in every bank and resets to 0x8 (timer running, bank 0).
- R2: In bank 0, addresses 0x0..0xC are seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, day of week, day units, day tens, month units, month tens, year units and year tens. Implemented bit widths are 4,3,4,3,4,2,3,4,2,4,1,4,4 in that address order. Unimplemented bits ignore writes and read 0. After reset the digits read 00:00:00, day 01, month 01, year 00, day of week 0.
- R3: Each tick while the timer is enabled adds one second. Seconds and minutes wrap 59 to 00 with a carry. In 24-hour mode, 23:59:59 becomes 00:00:00 and the day advances.
- R4: Bank 1 address 0xA bit 0 selects 24-hour (1, the reset value) or 12-hour (0) mode. In 12-hour mode, hours run 1..12 and hours-tens bit 1 is PM. A tick at 11:59:59 AM gives 12:00:00 PM, and a tick at 12:59:59 gives 01:00:00. A tick at 11:59:59 PM gives 12:00:00 AM and advances the day.
- R5: Bank 1 address 0xB bits 1:0 is the leap-year counter (reset 0, value 0 means a leap year). February ends on day 29 when the counter is 0 and on day 28 otherwise. April, June, September and November end on day 30, and the other months on day 31. Month 12 wraps to 1, and year 99 wraps to 00. The leap counter steps modulo 4 on each year change. Day of week wraps from 6 to 0.
- R6: While timer enable is 0 no digit moves on a tick. Any number of ticks in that time collapse into one pending second, which is applied on the first enabled cycle.
- R7: Banks 2 and 3 each store 13 full nibbles at 0x0..0xC. These are independent of each other and of the time digits.
- R8: Address 0xF is the reset/control register. Writing bit 1 discards a pending second. Writing bit 0 clears the ten alarm nibbles at bank 1 addresses 0x0..0x9. Bits 3:2 are stored and read back, and bits 1:0 read 0.
- R9: The test register at 0xE and bank 1 address 0xC read 0 and ignore writes.
- R10: A host write to a time digit in the same cycle as a tick takes the written value and turns the tick into a pending second, which advances the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Combinational read data for addr_i |

## Verification
The range and movement assertions assume that the host only writes valid BCD digits. They also assume the day of week stays below 7 and no calendar date lies past its month's end. The stimulus loads only legal dates and times, and it exercises the masking of unimplemented bits only on digits it reloads before the next tick. Ticks are single-cycle pulses, spaced at least one cycle apart except in the deliberate collapse and same-cycle cases.

// File: rtl/nrtc_pkg.sv
package nrtc_pkg;
   localparam int SEC_U = 0;
   localparam int SEC_T = 1;
   localparam int MIN_U = 2;
   localparam int MIN_T = 3;
   localparam int HR_U  = 4;
   localparam int HR_T  = 5;
   localparam int DOW   = 6;
   localparam int DAY_U = 7;
   localparam int DAY_T = 8;
   localparam int MON_U = 9;
   localparam int MON_T = 10;
   localparam int YR_U  = 11;
   localparam int YR_T  = 12;

   localparam logic [3:0] ADDR_MODE = 4'hD;
   localparam logic [3:0] ADDR_TEST = 4'hE;
   localparam logic [3:0] ADDR_CTRL = 4'hF;
   localparam logic [3:0] ADDR_H24  = 4'hA;
   localparam logic [3:0] ADDR_LEAP = 4'hB;

   typedef enum logic [1:0] {
      BANK_TIME = 2'd0,
      BANK_CFG  = 2'd1,
      BANK_RAMA = 2'd2,
      BANK_RAMB = 2'd3
   } bank_e;

   function automatic logic [6:0] bcd_val(input logic [3:0] t, input logic [3:0] u);
      return 7'(t * 10 + u);
   endfunction

   function automatic logic [7:0] val_bcd(input logic [6:0] v);
      logic [6:0] q;
      q = v / 7'd10;
      return {q[3:0], 4'(v - q * 7'd10)};
   endfunction

   function automatic logic [3:0] digit_mask(input int idx);
      case (idx)
         SEC_T, MIN_T, DOW: return 4'h7;
         HR_T, DAY_T:       return 4'h3;
         MON_T:             return 4'h1;
         default:           return 4'hF;
      endcase
   endfunction

   function automatic logic [6:0] month_len(input logic [6:0] mo, input logic [1:0] leap);
      case (mo)
         7'd2:                      return (leap == 2'd0) ? 7'd29 : 7'd28;
         7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
         default:                   return 7'd31;
      endcase
   endfunction
endpackage

// File: rtl/nrtc_nibble_ram.sv
module nrtc_nibble_ram #(
   parameter int DATA_W = 4,
   parameter int ADDR_W = 4,
   parameter int DEPTH  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   if (DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("nrtc_nibble_ram: DEPTH does not fit the address width");
   end

   logic [DEPTH-1:0][DATA_W-1:0] mem_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n || clr_i)
            mem_q[i] <= '0;
         else if (we_i && addr_i == ADDR_W'(i))
            mem_q[i] <= wdata_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < DEPTH; i++)
         if (addr_i == ADDR_W'(i)) rdata_o = mem_q[i];
   end

   AST_RAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_i && !clr_i) |=> $stable(mem_q)); // R7
endmodule

// File: rtl/nrtc_time_step.sv
module nrtc_time_step
   import nrtc_pkg::*;
#(
   parameter int SLOTS = 13
) (
   input  logic [SLOTS-1:0][3:0] cur_i,
   input  logic                  h24_i,
   input  logic [1:0]            leap_i,
   output logic [SLOTS-1:0][3:0] nxt_o,
   output logic [1:0]            leap_o
);
   logic [6:0] s, m, h, hn, d, mo, y;
   logic       cm, ch, cd, cmo, cy, pm, pm_n;
   logic [7:0] hb;

   always_comb begin
      nxt_o  = cur_i;
      leap_o = leap_i;
      s  = bcd_val(cur_i[SEC_T], cur_i[SEC_U]);
      m  = bcd_val(cur_i[MIN_T], cur_i[MIN_U]);
      d  = bcd_val(cur_i[DAY_T], cur_i[DAY_U]);
      mo = bcd_val(cur_i[MON_T], cur_i[MON_U]);
      y  = bcd_val(cur_i[YR_T], cur_i[YR_U]);
      pm = cur_i[HR_T][1];
      pm_n = pm;
      cd = 1'b0;
      // seconds always advance; each stage carries into the next
      cm = (s == 7'd59);
      {nxt_o[SEC_T], nxt_o[SEC_U]} = val_bcd(cm ? 7'd0 : s + 7'd1);
      ch = cm && (m == 7'd59);
      if (cm) {nxt_o[MIN_T], nxt_o[MIN_U]} = val_bcd(ch ? 7'd0 : m + 7'd1);
      if (h24_i) begin
         h  = bcd_val(cur_i[HR_T], cur_i[HR_U]);
         hn = h;
         if (ch) begin
            cd = (h == 7'd23);
            hn = cd ? 7'd0 : h + 7'd1;
         end
         hb = val_bcd(hn);
         nxt_o[HR_T] = hb[7:4];
         nxt_o[HR_U] = hb[3:0];
      end else begin
         h  = bcd_val({3'b000, cur_i[HR_T][0]}, cur_i[HR_U]);
         hn = h;
         if (ch) begin
            if (h == 7'd11) begin
               hn   = 7'd12;
               pm_n = !pm;
               cd   = pm;
            end else if (h >= 7'd12) begin
               hn = 7'd1;
            end else begin
               hn = h + 7'd1;
            end
         end
         hb = val_bcd(hn);
         nxt_o[HR_T] = {2'b00, pm_n, hb[4]};
         nxt_o[HR_U] = hb[3:0];
      end
      cmo = cd && (d >= month_len(mo, leap_i));
      cy  = cmo && (mo >= 7'd12);
      if (cd) begin
         nxt_o[DOW] = (cur_i[DOW] >= 4'd6) ? 4'd0 : cur_i[DOW] + 4'd1;
         {nxt_o[DAY_T], nxt_o[DAY_U]} = val_bcd(cmo ? 7'd1 : d + 7'd1);
      end
      if (cmo) {nxt_o[MON_T], nxt_o[MON_U]} = val_bcd(cy ? 7'd1 : mo + 7'd1);
      if (cy) begin
         {nxt_o[YR_T], nxt_o[YR_U]} = val_bcd((y >= 7'd99) ? 7'd0 : y + 7'd1);
         leap_o = leap_i + 2'd1;
      end
   end
endmodule

// File: rtl/nrtc_regfile.sv
module nrtc_regfile
   import nrtc_pkg::*;
#(
   parameter int DATA_W      = 4,
   parameter int ADDR_W      = 4,
   parameter int SLOTS       = 13,
   parameter int ALARM_SLOTS = 10,
   parameter int USER_BANKS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int TIMER_BIT = DATA_W - 1;

   if (DATA_W != 4 || ADDR_W != 4) begin : g_bad_bus
      $error("nrtc_regfile: the register map needs a 4-bit bus and 4-bit address");
   end
   if (SLOTS != 13) begin : g_bad_slots
      $error("nrtc_regfile: the time layout has exactly 13 digits");
   end
   if (ALARM_SLOTS > 10 || USER_BANKS != 2) begin : g_bad_cfg
      $error("nrtc_regfile: alarm nibbles must stay below 0xA and two RAM banks are mapped");
   end

   logic [DATA_W-1:0]            mode_q;
   logic [SLOTS-1:0][3:0]        time_q, time_nxt;
   logic [1:0]                   leap_q, leap_nxt, pulse_q;
   logic                         h24_q, pend_q;
   bank_e                        bank;
   logic                         is_ctl, wr_time, wr_cfg, wr_ctrl, adv, timer_en;
   logic [DATA_W-1:0]            alarm_rd, time_rd;
   logic [USER_BANKS-1:0][DATA_W-1:0] user_rd;

   assign bank     = bank_e'(mode_q[1:0]);
   assign timer_en = mode_q[TIMER_BIT];
   assign is_ctl   = (addr_i >= ADDR_MODE);
   assign wr_time  = wr_en_i && !is_ctl && bank == BANK_TIME;
   assign wr_cfg   = wr_en_i && !is_ctl && bank == BANK_CFG;
   assign wr_ctrl  = wr_en_i && addr_i == ADDR_CTRL;
   assign adv      = timer_en && !wr_time && (tick_i || pend_q);

   nrtc_time_step #(.SLOTS(SLOTS)) u_step (
      .cur_i  (time_q),
      .h24_i  (h24_q),
      .leap_i (leap_q),
      .nxt_o  (time_nxt),
      .leap_o (leap_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q        <= '0;
         mode_q[TIMER_BIT] <= 1'b1;
         time_q        <= '0;
         time_q[DAY_U] <= 4'd1;
         time_q[MON_U] <= 4'd1;
         leap_q        <= '0;
         h24_q         <= 1'b1;
         pend_q        <= 1'b0;
         pulse_q       <= '0;
      end else begin
         if (wr_en_i && addr_i == ADDR_MODE) mode_q <= wdata_i;
         if (wr_ctrl) pulse_q <= wdata_i[3:2];
         pend_q <= !(wr_ctrl && wdata_i[1]) && (tick_i || pend_q) && !adv;
         if (wr_time) begin
            for (int i = 0; i < SLOTS; i++)
               if (addr_i == ADDR_W'(i)) time_q[i] <= wdata_i & digit_mask(i);
         end else if (adv) begin
            time_q <= time_nxt;
         end
         if (wr_cfg && addr_i == ADDR_H24) h24_q <= wdata_i[0];
         if (wr_cfg && addr_i == ADDR_LEAP) leap_q <= wdata_i[1:0];
         else if (adv) leap_q <= leap_nxt;
      end
   end

   nrtc_nibble_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(ALARM_SLOTS)) u_alarm (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (wr_ctrl && wdata_i[0]),
      .we_i    (wr_cfg),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .rdata_o (alarm_rd)
   );

   for (genvar b = 0; b < USER_BANKS; b++) begin : g_user_ram
      nrtc_nibble_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(SLOTS)) u_ram (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_i   (1'b0),
         .we_i    (wr_en_i && !is_ctl && bank == bank_e'(2 + b)),
         .addr_i  (addr_i),
         .wdata_i (wdata_i),
         .rdata_o (user_rd[b])
      );
   end

   always_comb begin
      time_rd = '0;
      for (int i = 0; i < SLOTS; i++)
         if (addr_i == ADDR_W'(i)) time_rd = time_q[i];
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_MODE)      rdata_o = mode_q;
      else if (addr_i == ADDR_CTRL) rdata_o = {pulse_q, 2'b00};
      else if (!is_ctl) begin
         case (bank)
            BANK_TIME: rdata_o = time_rd;
            BANK_CFG: begin
               rdata_o = alarm_rd;
               if (addr_i == ADDR_H24)  rdata_o = {3'b000, h24_q};
               if (addr_i == ADDR_LEAP) rdata_o = {2'b00, leap_q};
            end
            BANK_RAMA: rdata_o = user_rd[0];
            default:   rdata_o = user_rd[1];
         endcase
      end
   end

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!timer_en && !wr_time) |=> $stable(time_q)); // R6
   AST_PEND_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && timer_en && !wr_time) |=> !pend_q); // R6
   AST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_en && (tick_i || pend_q) && !wr_time) |=> (time_q[SEC_U] != $past(time_q[SEC_U]))); // R3
   AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      time_q[DOW] < 4'd7); // R5
   AST_TIME_WR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_time && tick_i && !(wr_ctrl && wdata_i[1])) |=> pend_q); // R10
endmodule

// File: tb/tb_nrtc_regfile.sv
`timescale 1ns/1ps
module tb_nrtc_regfile;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic [3:0] addr_i = 4'h0;
   logic       wr_en_i = 1'b0;
   logic [3:0] wdata_i = 4'h0;
   logic [3:0] rdata_o;
   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   nrtc_regfile dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
      .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      addr_i = 4'(a); wdata_i = 4'(d); wr_en_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      addr_i = 4'(a);
      #1 d = int'(rdata_o);
   endtask

   task automatic expect_rd(input string tag, input int a, input int exp);
      int v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic tick();
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic cfg_wr(input int a, input int d);
      wr(13, 4'h9); wr(a, d); wr(13, 4'h8);
   endtask

   task automatic cfg_expect(input string tag, input int a, input int exp);
      wr(13, 4'h9); expect_rd(tag, a, exp); wr(13, 4'h8);
   endtask

   task automatic load(input int y, input int mo, input int dy, input int dw,
                       input int ht, input int hu, input int mi, input int se);
      wr(0, se % 10); wr(1, se / 10); wr(2, mi % 10); wr(3, mi / 10);
      wr(4, hu); wr(5, ht); wr(6, dw); wr(7, dy % 10); wr(8, dy / 10);
      wr(9, mo % 10); wr(10, mo / 10); wr(11, y % 10); wr(12, y / 10);
   endtask

   task automatic expect_date(input string tag, input int y, input int mo, input int dy);
      expect_rd(tag, 7, dy % 10); expect_rd(tag, 8, dy / 10);
      expect_rd(tag, 9, mo % 10); expect_rd(tag, 10, mo / 10);
      expect_rd(tag, 11, y % 10); expect_rd(tag, 12, y / 10);
   endtask

   task automatic t_reset();
      expect_rd("R1 mode reset", 13, 8);
      expect_rd("R2 sec units reset", 0, 0);
      expect_rd("R2 hour tens reset", 5, 0);
      expect_rd("R2 day units reset", 7, 1);
      expect_rd("R2 month units reset", 9, 1);
      cfg_expect("R4 24h reset", 10, 1);
      cfg_expect("R5 leap reset", 11, 0);
   endtask

   task automatic t_mask();
      wr(1, 4'hF); expect_rd("R2 sec tens mask", 1, 7);
      wr(5, 4'hF); expect_rd("R2 hour tens mask", 5, 3);
      wr(10, 4'hF); expect_rd("R2 month tens mask", 10, 1);
      wr(8, 4'hF); expect_rd("R2 day tens mask", 8, 3);
      wr(13, 4'hA); expect_rd("R1 mode in bank 2", 13, 4'hA);
      wr(13, 4'h8);
      load(0, 1, 1, 0, 0, 0, 0, 0);
   endtask

   task automatic t_24h();
      load(0, 1, 1, 0, 2, 3, 59, 59);
      tick();
      expect_rd("R3 sec wrap", 0, 0); expect_rd("R3 sec tens wrap", 1, 0);
      expect_rd("R3 min wrap", 2, 0); expect_rd("R3 min tens wrap", 3, 0);
      expect_rd("R3 hour wrap", 4, 0); expect_rd("R3 hour tens wrap", 5, 0);
      expect_rd("R3 day advance", 7, 2); expect_rd("R3 dow advance", 6, 1);
      load(0, 1, 1, 0, 1, 2, 34, 8);
      tick(); expect_rd("R3 sec 08->09", 0, 9);
      tick(); expect_rd("R3 sec 09->10 units", 0, 0); expect_rd("R3 sec 09->10 tens", 1, 1);
      expect_rd("R3 min untouched", 2, 4);
   endtask

   task automatic t_12h();
      cfg_wr(10, 0);
      load(0, 3, 5, 2, 1, 1, 59, 59);
      tick();
      expect_rd("R4 11AM->12PM tens", 5, 3); expect_rd("R4 11AM->12PM units", 4, 2);
      expect_rd("R4 noon no day", 7, 5);
      load(0, 3, 5, 2, 3, 2, 59, 59);
      tick();
      expect_rd("R4 12PM->1PM tens", 5, 2); expect_rd("R4 12PM->1PM units", 4, 1);
      load(0, 3, 5, 2, 3, 1, 59, 59);
      tick();
      expect_rd("R4 11PM->12AM tens", 5, 1); expect_rd("R4 11PM->12AM units", 4, 2);
      expect_rd("R4 midnight day", 7, 6); expect_rd("R4 midnight dow", 6, 3);
      cfg_wr(10, 1);
   endtask

   task automatic t_calendar();
      cfg_wr(11, 1);
      load(1, 2, 28, 0, 2, 3, 59, 59); tick();
      expect_date("R5 feb28 non-leap", 1, 3, 1);
      cfg_wr(11, 0);
      load(4, 2, 28, 0, 2, 3, 59, 59); tick();
      expect_date("R5 feb28 leap", 4, 2, 29);
      load(4, 2, 29, 0, 2, 3, 59, 59); tick();
      expect_date("R5 feb29 leap", 4, 3, 1);
      load(4, 4, 30, 0, 2, 3, 59, 59); tick();
      expect_date("R5 apr30", 4, 5, 1);
      load(4, 5, 30, 0, 2, 3, 59, 59); tick();
      expect_date("R5 may30", 4, 5, 31);
      cfg_wr(11, 3);
      load(99, 12, 31, 6, 2, 3, 59, 59); tick();
      expect_date("R5 year wrap", 0, 1, 1);
      expect_rd("R5 dow 6->0", 6, 0);
      cfg_expect("R5 leap 3->0", 11, 0);
   endtask

   task automatic t_freeze();
      load(0, 1, 1, 0, 0, 0, 0, 20);
      wr(13, 4'h0);
      tick(); tick(); tick();
      expect_rd("R6 frozen units", 0, 0);
      expect_rd("R6 frozen tens", 1, 2);
      wr(13, 4'h8);
      expect_rd("R6 pending applied", 0, 1);
      expect_rd("R6 ticks collapse", 0, 1);
   endtask

   task automatic t_same_cycle();
      load(0, 1, 1, 0, 0, 0, 0, 9);
      @(negedge clk);
      addr_i = 4'h0; wdata_i = 4'h3; wr_en_i = 1'b1; tick_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0; tick_i = 1'b0;
      expect_rd("R10 write wins then pending units", 0, 4);
      expect_rd("R10 write wins tens", 1, 0);
   endtask

   task automatic t_ram();
      load(0, 1, 1, 0, 0, 0, 0, 0);
      wr(13, 4'hA);
      for (int i = 0; i < 13; i++) wr(i, (i + 3) % 16);
      wr(13, 4'hB);
      for (int i = 0; i < 13; i++) wr(i, 15 - i);
      wr(13, 4'hA);
      expect_rd("R7 bank A word 0", 0, 3);
      expect_rd("R7 bank A word 12", 12, 15);
      wr(13, 4'hB);
      expect_rd("R7 bank B word 0", 0, 15);
      expect_rd("R7 bank B word 12", 12, 3);
      wr(13, 4'h8);
      expect_rd("R7 time untouched sec", 0, 0);
      expect_rd("R7 time untouched day", 7, 1);
   endtask

   task automatic t_ctrl();
      load(0, 1, 1, 0, 0, 0, 0, 30);
      wr(13, 4'h0);
      tick();
      wr(15, 4'h2);
      wr(13, 4'h8);
      expect_rd("R8 pending discarded", 0, 0);
      expect_rd("R8 pending discarded 2", 0, 0);
      wr(15, 4'hE);
      expect_rd("R8 pulse bits read back", 15, 12);
      wr(13, 4'h9);
      wr(3, 9); wr(9, 5);
      expect_rd("R8 alarm stored", 3, 9);
      wr(15, 4'h1);
      expect_rd("R8 alarm cleared 3", 3, 0);
      expect_rd("R8 alarm cleared 9", 9, 0);
      expect_rd("R8 ctrl after clear", 15, 0);
      wr(13, 4'h8);
   endtask

   task automatic t_test_reg();
      wr(14, 4'hF);
      expect_rd("R9 test reg reads 0", 14, 0);
      wr(13, 4'h9);
      wr(12, 4'hF);
      expect_rd("R9 cfg 0xC reads 0", 12, 0);
      expect_rd("R9 24h intact", 10, 1);
      wr(13, 4'h8);
      expect_rd("R9 time unaffected", 12, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mask();
      t_24h();
      t_12h();
      t_calendar();
      t_freeze();
      t_same_cycle();
      t_ram();
      t_ctrl();
      t_test_reg();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule